// File: doc/BRIEF.md
# Clear-on-Read Event Counter Bank

A bank of four 16-bit event counters, each fed by its own single-cycle strobe and read by an 8-bit host through a synchronous register port with a 9-bit address. Each counter is seen as two byte registers at consecutive addresses: the even address holds the upper byte and the odd address holds the lower byte.

Any read of either byte returns that byte and clears the whole counter in the same access. The byte that was not read is saved in one shared holding register. The host fetches it with the next read, so the full 16-bit value is always recovered, whichever byte was read first. An event that arrives during the clearing read is kept, and counters stop at full scale instead of wrapping.

Top module: `evt_cnt_bank`

## Requirements
- R1: Counter k (k = 0..3) counts one for every cycle in which `evt_i[k]` is high. Its upper byte is at address 0x040+2k and its lower byte is at 0x041+2k.
- R2: A cycle with `rd_en_i` high and a counter byte address puts that byte of the counter's pre-read value on `rdata_o` after the next rising edge. The counter becomes 0x0000 in that same edge.
- R3: If the lower byte is read first, a later direct read of the upper byte of the same counter returns 0x00.
- R4: A counter byte read loads the other byte into the holding register. A read of address 0x056 returns the holding register and changes neither it nor any counter.
- R5: If a counter's strobe is high in the cycle of its clearing read, the counter holds 0x0001 after that edge.
- R6: A counter at 0xFFFF stays at 0xFFFF when further events arrive.
- R7: Host writes (`wr_en_i` high) to counter addresses or to 0x056 change no counter and do not change the holding register.
- R8: Reads of any other address return 0x00 and have no side effect. All 9 address bits are decoded.
- R9: After reset, `rdata_o`, the holding register and all counters are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | 4 | One event strobe per counter |
| rd_en_i | input | 1 | Single-cycle read request |
| wr_en_i | input | 1 | Write request (ignored) |
| addr_i | input | 9 | Register address |
| wdata_i | input | 8 | Write data (ignored) |
| rdata_o | output | 8 | Registered read data |

## Verification
A wrong counter value shows at the ports only when the host reads it, one cycle after the read request. Because the read also clears the counter, each observation consumes the state it reveals. A stale or wrongly loaded holding register shows on the very next read of 0x056. A missing clear shows as a non-zero byte on the second direct read of the same counter. The bench therefore pairs every byte read with a holding-register read or a repeated direct read, so that both halves and the clear are each seen within two reads.

// File: rtl/evt_cnt_pkg.sv
package evt_cnt_pkg;
  localparam int unsigned CNT_W_DEF  = 16;
  localparam int unsigned BYTE_W_DEF = 8;
  localparam int unsigned ADDR_W_DEF = 9;
  localparam int unsigned N_CNT_DEF  = 4;
  localparam logic [8:0]  BASE_DEF   = 9'h040;
  localparam logic [8:0]  HOLD_DEF   = 9'h056;
endpackage

// File: rtl/evt_cnt_cell.sv
module evt_cnt_cell #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)                     cnt_d = inc_i ? ONE : '0;  // keep coincident event
    else if (inc_i && cnt_q != MAX) cnt_d = cnt_q + ONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;

  assign cnt_o = cnt_q;

  a_r6_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == MAX && !clr_i) |=> cnt_q == MAX);
  a_r5_evt_on_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && inc_i) |=> cnt_q == ONE);
  a_r2_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !inc_i) |=> cnt_q == '0);
  a_r1_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && inc_i && cnt_q != MAX) |=> cnt_q == $past(cnt_q) + ONE);
endmodule

// File: rtl/evt_cnt_decode.sv
module evt_cnt_decode #(
  parameter int unsigned ADDR_W = 9,
  parameter int unsigned N_CNT  = 4,
  parameter logic [ADDR_W-1:0] BASE = 9'h040,
  parameter logic [ADDR_W-1:0] HOLD = 9'h056
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [N_CNT-1:0]  hi_hit_o,
  output logic [N_CNT-1:0]  lo_hit_o,
  output logic              hold_hit_o
);
  for (genvar i = 0; i < N_CNT; i++) begin : g_dec
    localparam logic [ADDR_W-1:0] HI_A = BASE + ADDR_W'(2*i);
    localparam logic [ADDR_W-1:0] LO_A = BASE + ADDR_W'(2*i + 1);
    assign hi_hit_o[i] = (addr_i == HI_A);
    assign lo_hit_o[i] = (addr_i == LO_A);
  end
  assign hold_hit_o = (addr_i == HOLD);

  // R8: at most one register selected per address
  a_r8_onehot_sel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({hi_hit_o, lo_hit_o, hold_hit_o}));
endmodule

// File: rtl/evt_cnt_readout.sv
module evt_cnt_readout #(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned N_CNT  = 4
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        rd_en_i,
  input  logic [N_CNT-1:0]            hi_hit_i,
  input  logic [N_CNT-1:0]            lo_hit_i,
  input  logic                        hold_hit_i,
  input  logic [N_CNT-1:0][CNT_W-1:0] cnt_i,
  output logic [BYTE_W-1:0]           rdata_o
);
  logic [BYTE_W-1:0] sel_byte, oth_byte, hold_q, rdata_q;
  logic              cnt_hit;

  always_comb begin
    sel_byte = '0;
    oth_byte = '0;
    for (int i = 0; i < N_CNT; i++) begin
      if (hi_hit_i[i]) begin
        sel_byte = cnt_i[i][CNT_W-1 -: BYTE_W];
        oth_byte = cnt_i[i][BYTE_W-1:0];
      end
      if (lo_hit_i[i]) begin
        sel_byte = cnt_i[i][BYTE_W-1:0];
        oth_byte = cnt_i[i][CNT_W-1 -: BYTE_W];
      end
    end
  end

  assign cnt_hit = |{hi_hit_i, lo_hit_i};

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      hold_q  <= '0;
      rdata_q <= '0;
    end else if (rd_en_i) begin
      if (cnt_hit) begin
        rdata_q <= sel_byte;
        hold_q  <= oth_byte;
      end else if (hold_hit_i) begin
        rdata_q <= hold_q;
      end else begin
        rdata_q <= '0;
      end
    end

  assign rdata_o = rdata_q;

  a_r4_hold_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_en_i && cnt_hit) |=> $stable(hold_q));
  a_r8_unmapped_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !cnt_hit && !hold_hit_i) |=> rdata_q == '0);
  a_r4_hold_return: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && hold_hit_i) |=> rdata_q == $past(hold_q));
endmodule

// File: rtl/evt_cnt_bank.sv
module evt_cnt_bank
  import evt_cnt_pkg::*;
#(
  parameter int unsigned CNT_W  = CNT_W_DEF,
  parameter int unsigned ADDR_W = ADDR_W_DEF,
  parameter int unsigned N_CNT  = N_CNT_DEF,
  parameter logic [ADDR_W-1:0] BASE = BASE_DEF,
  parameter logic [ADDR_W-1:0] HOLD = HOLD_DEF,
  localparam int unsigned BYTE_W = CNT_W / 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_CNT-1:0]  evt_i,
  input  logic              rd_en_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] rdata_o
);
  logic [N_CNT-1:0]            hi_hit, lo_hit;
  logic                        hold_hit;
  logic [N_CNT-1:0][CNT_W-1:0] cnt;

  // R7: write side has no target in this bank
  logic unused_wr;
  assign unused_wr = ^{wr_en_i, wdata_i};

  evt_cnt_decode #(
    .ADDR_W(ADDR_W), .N_CNT(N_CNT), .BASE(BASE), .HOLD(HOLD)
  ) u_decode (
    .clk_i, .rst_ni, .addr_i,
    .hi_hit_o(hi_hit), .lo_hit_o(lo_hit), .hold_hit_o(hold_hit)
  );

  for (genvar i = 0; i < N_CNT; i++) begin : g_cnt
    evt_cnt_cell #(.CNT_W(CNT_W)) u_cell (
      .clk_i, .rst_ni,
      .inc_i(evt_i[i]),
      .clr_i(rd_en_i && (hi_hit[i] || lo_hit[i])),
      .cnt_o(cnt[i])
    );
  end

  evt_cnt_readout #(
    .CNT_W(CNT_W), .BYTE_W(BYTE_W), .N_CNT(N_CNT)
  ) u_readout (
    .clk_i, .rst_ni, .rd_en_i,
    .hi_hit_i(hi_hit), .lo_hit_i(lo_hit), .hold_hit_i(hold_hit),
    .cnt_i(cnt), .rdata_o
  );
endmodule

// File: tb/evt_cnt_bank_bench.sv
`timescale 1ns/1ps
module evt_cnt_bank_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] evt = '0;
  logic       rd_en = 1'b0, wr_en = 1'b0;
  logic [8:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  int checks = 0, failures = 0;

  always #4 clk = ~clk;  // 125 MHz

  evt_cnt_bank u_evt_cnt_bank (
    .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .rd_en_i(rd_en),
    .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata)
  );

  // vector: op(2) addr(9) mask(4) count(12) exp(8) req(4)
  function automatic logic [38:0] mk(input logic [1:0] op, input logic [8:0] a,
                                     input logic [3:0] m, input logic [11:0] n,
                                     input logic [7:0] e, input logic [3:0] r);
    return {op, a, m, n, e, r};
  endfunction
  localparam int NV = 20;
  localparam logic [38:0] VEC [NV] = '{
    mk(2'd0, 9'h000, 4'b0001, 12'd3,   8'h00, 4'd1),  // c0=3
    mk(2'd0, 9'h000, 4'b0010, 12'd300, 8'h00, 4'd1),  // c1=0x012C
    mk(2'd1, 9'h040, 4'b0000, 12'd0,   8'h00, 4'd2),  // R2 c0 high
    mk(2'd1, 9'h056, 4'b0000, 12'd0,   8'h03, 4'd4),  // R4 other byte
    mk(2'd1, 9'h043, 4'b0000, 12'd0,   8'h2C, 4'd2),  // R2 c1 low
    mk(2'd1, 9'h056, 4'b0000, 12'd0,   8'h01, 4'd4),
    mk(2'd1, 9'h056, 4'b0000, 12'd0,   8'h01, 4'd4),  // R4 hold read no side effect
    mk(2'd1, 9'h042, 4'b0000, 12'd0,   8'h00, 4'd3),  // R3 cleared by low read
    mk(2'd1, 9'h041, 4'b0000, 12'd0,   8'h00, 4'd2),
    mk(2'd0, 9'h000, 4'b1111, 12'd2,   8'h00, 4'd1),  // all =2
    mk(2'd1, 9'h047, 4'b0000, 12'd0,   8'h02, 4'd1),  // R1 c3 low
    mk(2'd1, 9'h056, 4'b0000, 12'd0,   8'h00, 4'd4),
    mk(2'd1, 9'h044, 4'b0000, 12'd0,   8'h00, 4'd1),  // c2 high
    mk(2'd1, 9'h056, 4'b0000, 12'd0,   8'h02, 4'd4),
    mk(2'd1, 9'h010, 4'b0000, 12'd0,   8'h00, 4'd8),  // R8 unmapped
    mk(2'd1, 9'h056, 4'b0000, 12'd0,   8'h02, 4'd8),  // hold unchanged
    mk(2'd1, 9'h141, 4'b0000, 12'd0,   8'h00, 4'd8),  // R8 alias of 0x041 by upper bit
    mk(2'd1, 9'h041, 4'b0000, 12'd0,   8'h02, 4'd8),  // c0 untouched
    mk(2'd1, 9'h045, 4'b0000, 12'd0,   8'h00, 4'd3),  // c2 cleared already
    mk(2'd1, 9'h042, 4'b0000, 12'd0,   8'h00, 4'd1)   // c1 high
  };

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input int req);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL R%0d actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic pulse(input logic [3:0] m, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); evt = m;
    end
    @(negedge clk); evt = '0;
  endtask

  task automatic rd(input logic [8:0] a, input logic [7:0] exp, input int req);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; addr = '0;
    check(rdata, exp, req);
  endtask

  task automatic wr(input logic [8:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0; addr = '0; wdata = '0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(rdata, 8'h00, 9);                 // R9 reset output
    rst_n = 1'b1;
    rd(9'h040, 8'h00, 9);                   // R9 counter zero
    rd(9'h056, 8'h00, 9);                   // R9 hold zero

    for (int v = 0; v < NV; v++) begin
      if (VEC[v][38:37] == 2'd0) pulse(VEC[v][27:24], int'(VEC[v][23:12]));
      else rd(VEC[v][36:28], VEC[v][11:4], int'(VEC[v][3:0]));
    end

    // R5: event coincident with clearing read
    pulse(4'b0001, 5);
    @(negedge clk); rd_en = 1'b1; addr = 9'h041; evt = 4'b0001;
    @(negedge clk); rd_en = 1'b0; addr = '0; evt = '0;
    check(rdata, 8'h05, 5);
    rd(9'h041, 8'h01, 5);
    rd(9'h056, 8'h00, 5);

    // R7: writes ignored
    pulse(4'b0010, 7);
    rd(9'h040, 8'h00, 7);                   // hold <= 0x00
    wr(9'h042, 8'hAA);
    wr(9'h043, 8'h55);
    wr(9'h056, 8'hEE);
    rd(9'h056, 8'h00, 7);
    rd(9'h043, 8'h07, 7);
    rd(9'h056, 8'h00, 7);

    // R6: saturation
    pulse(4'b1000, 70000);
    rd(9'h046, 8'hFF, 6);
    rd(9'h056, 8'hFF, 6);
    rd(9'h047, 8'h00, 6);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule